// File: doc/BRIEF.md
# Multi-Level Cell Read Fault Injector

This block sits in a stream of stored level codes on their way to weight-decoding logic and corrupts some of them on purpose, the way a dense multi-level storage cell misreads. Each accepted cell code is replaced, with a programmable probability, by one of its immediate neighbours. Decoders, error-tolerance schemes and level-to-value mappings can then be stress-tested in hardware at known fault rates.

Every level has its own pair of 16-bit probabilities: one for reading one step low and one for reading one step high. The erased level (code 0) can only drift upward. The highest level in use can only drift downward. The number of levels in use is set per cell from 2 to 16. A seedable 32-bit LFSR supplies one 16-bit draw per accepted cell, so a software model that knows the seed can predict every injected fault exactly. The result leaves through a register one cycle after the input, with a flag for an injected fault and a bit for its direction.

Top module: `mlc_fault_inject`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid`, `out_fault`, `out_dir_up` and `out_level` are 0. All 32 thresholds are cleared to 0 and the LFSR state is set to 32'h0000_0001.
- R2: `out_valid` equals `in_valid` from the previous cycle. When no fault is injected, `out_level` equals the `in_level` presented one cycle earlier.
- R3: The LFSR is a right-shifting Galois register with feedback mask 32'h8020_0003. The mask is XORed into the state after the shift whenever the bit shifted out is 1. The state advances exactly once on each cycle with `in_valid` high and holds otherwise. The draw used by a cell is the upper state half XORed with the lower state half, taken from the state before that cell's advance.
- R4: When `seed_load` is high, the next state is `seed_value`, or 32'h0000_0001 if `seed_value` is zero. A load takes priority over advancing. A cell accepted in the same cycle uses the draw from the state before the load.
- R5: A cell at level n (n >= 1, n in range) reads as n-1 when the draw r satisfies r < down[n].
- R6: A cell at level n (n below the top level) reads as n+1 when down[n] <= r < down[n] + up[n]. The sum is formed without overflow, on 17 bits.
- R7: The down threshold of level 0 is ignored, so a level-0 cell never reads low.
- R8: The top level is `levels_cfg`-1 and its up threshold is ignored, so it never reads high. A `levels_cfg` below 2 acts as 2 and one above 16 acts as 16.
- R9: A code at or above the effective level count passes through unchanged, with no fault.
- R10: A write with `thr_we` high stores `thr_data` into the down threshold (`thr_dir`=0) or the up threshold (`thr_dir`=1) of level `thr_level`. It affects cells accepted from the next cycle on. A cell accepted in the same cycle sees the old value.
- R11: With all thresholds at 0, every cell passes unchanged, and the block acts as a one-cycle pipeline register.
- R12: `out_fault` is 1 exactly when `out_level` differs from the input code. Then `out_dir_up`=1 means the output is the input plus one, and `out_dir_up`=0 means the input minus one. When `out_valid` is 0, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load the LFSR from `seed_value` |
| seed_value | input | 32 | LFSR seed |
| thr_we | input | 1 | Threshold write strobe |
| thr_level | input | 4 | Level whose threshold is written |
| thr_dir | input | 1 | 0 = down threshold, 1 = up threshold |
| thr_data | input | 16 | Threshold value, probability times 65536 |
| in_valid | input | 1 | Cell code strobe |
| in_level | input | 4 | Programmed level code |
| levels_cfg | input | 5 | Number of levels per cell (2 to 16) |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_level | output | 4 | Level code as read, possibly shifted |
| out_fault | output | 1 | A fault was injected on this cell |
| out_dir_up | output | 1 | Direction of the injected fault |

## Verification
Two pairs of functions can fall in the same cycle: a threshold write and a cell read of the very level being written, and a seed load and a cell read. The bench drives each pair on one clock edge. In the first case the cell must be judged against the old threshold and the next cell against the new one. In the second case the cell must use the pre-load draw and the following cell the loaded seed. Around these collisions, near-exhaustive sweeps cover every level code under several level counts, including the clamped ones. A bench-side LFSR and threshold table give the exact expected fault for each cell.

// File: rtl/mlc_fi_pkg.sv
package mlc_fi_pkg;
  localparam int LEVEL_W = 4;
  localparam int PROB_W  = 16;
  localparam int LFSR_W  = 32;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 32'h8020_0003;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } fi_dir_e;
endpackage

// File: rtl/mlc_fi_lfsr.sv
module mlc_fi_lfsr #(
  parameter int LFSR_W = mlc_fi_pkg::LFSR_W,
  parameter int DRAW_W = mlc_fi_pkg::PROB_W,
  parameter logic [LFSR_W-1:0] MASK = mlc_fi_pkg::LFSR_MASK,
  parameter logic [LFSR_W-1:0] RESET_SEED = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              advance,
  output logic [LFSR_W-1:0] state,
  output logic [DRAW_W-1:0] draw
);
  localparam int CHUNKS = LFSR_W / DRAW_W;

  logic [LFSR_W-1:0] nxt;
  logic [LFSR_W-1:0] seed_fix;

  always_comb begin
    nxt = state >> 1;
    if (state[0]) nxt = nxt ^ MASK;
    seed_fix = (seed == '0) ? LFSR_W'(1) : seed;
  end

  always_comb begin
    draw = '0;
    for (int k = 0; k < CHUNKS; k++) begin
      draw = draw ^ state[k*DRAW_W +: DRAW_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= RESET_SEED;
    else if (load)    state <= seed_fix;
    else if (advance) state <= nxt;
  end
endmodule

// File: rtl/mlc_fi_thresh_bank.sv
module mlc_fi_thresh_bank #(
  parameter int LEVEL_W = mlc_fi_pkg::LEVEL_W,
  parameter int PROB_W  = mlc_fi_pkg::PROB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [LEVEL_W-1:0] wr_level,
  input  logic               wr_dir,
  input  logic [PROB_W-1:0]  wr_data,
  input  logic [LEVEL_W-1:0] rd_level,
  output logic [PROB_W-1:0]  rd_down,
  output logic [PROB_W-1:0]  rd_up
);
  localparam int NUM_LEVELS = 1 << LEVEL_W;

  logic [PROB_W-1:0] tab_down [NUM_LEVELS];
  logic [PROB_W-1:0] tab_up   [NUM_LEVELS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LEVELS; i++) begin
        tab_down[i] <= '0;
        tab_up[i]   <= '0;
      end
    end else if (we) begin
      if (wr_dir == mlc_fi_pkg::DIR_UP) tab_up[wr_level]   <= wr_data;
      else                              tab_down[wr_level] <= wr_data;
    end
  end

  assign rd_down = tab_down[rd_level];
  assign rd_up   = tab_up[rd_level];
endmodule

// File: rtl/mlc_fi_decide.sv
module mlc_fi_decide #(
  parameter int LEVEL_W = mlc_fi_pkg::LEVEL_W,
  parameter int PROB_W  = mlc_fi_pkg::PROB_W
) (
  input  logic [LEVEL_W-1:0] level,
  input  logic [LEVEL_W:0]   levels_cfg,
  input  logic [PROB_W-1:0]  draw,
  input  logic [PROB_W-1:0]  p_down,
  input  logic [PROB_W-1:0]  p_up,
  output logic [LEVEL_W-1:0] level_out,
  output logic               fault,
  output logic               dir_up
);
  localparam int CFG_W = LEVEL_W + 1;
  localparam logic [CFG_W-1:0] MIN_LEV = CFG_W'(2);
  localparam logic [CFG_W-1:0] MAX_LEV = CFG_W'(1 << LEVEL_W);

  logic [CFG_W-1:0]  cfg_eff;
  logic [CFG_W-1:0]  top;
  logic [CFG_W-1:0]  lvl_ext;
  logic [PROB_W-1:0] dn_eff;
  logic [PROB_W-1:0] up_eff;
  logic [PROB_W:0]   band;
  logic              in_range;

  always_comb begin
    if (levels_cfg < MIN_LEV)      cfg_eff = MIN_LEV;
    else if (levels_cfg > MAX_LEV) cfg_eff = MAX_LEV;
    else                           cfg_eff = levels_cfg;
    top      = cfg_eff - CFG_W'(1);
    lvl_ext  = {1'b0, level};
    in_range = (lvl_ext <= top);
    dn_eff   = (level == '0)    ? '0 : p_down;
    up_eff   = (lvl_ext == top) ? '0 : p_up;
    band     = {1'b0, dn_eff} + {1'b0, up_eff};

    level_out = level;
    fault     = 1'b0;
    dir_up    = 1'b0;
    if (in_range) begin
      if (draw < dn_eff) begin
        level_out = level - LEVEL_W'(1);
        fault     = 1'b1;
      end else if ({1'b0, draw} < band) begin
        level_out = level + LEVEL_W'(1);
        fault     = 1'b1;
        dir_up    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mlc_fault_inject.sv
module mlc_fault_inject #(
  parameter int LEVEL_W = mlc_fi_pkg::LEVEL_W,
  parameter int PROB_W  = mlc_fi_pkg::PROB_W,
  parameter logic [mlc_fi_pkg::LFSR_W-1:0] RESET_SEED = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          seed_load,
  input  logic [mlc_fi_pkg::LFSR_W-1:0] seed_value,
  input  logic                          thr_we,
  input  logic [LEVEL_W-1:0]            thr_level,
  input  logic                          thr_dir,
  input  logic [PROB_W-1:0]             thr_data,
  input  logic                          in_valid,
  input  logic [LEVEL_W-1:0]            in_level,
  input  logic [LEVEL_W:0]              levels_cfg,
  output logic                          out_valid,
  output logic [LEVEL_W-1:0]            out_level,
  output logic                          out_fault,
  output logic                          out_dir_up
);
  localparam int LFSR_W = mlc_fi_pkg::LFSR_W;

  logic [LFSR_W-1:0]  rng_state;
  logic [PROB_W-1:0]  rng_draw;
  logic [PROB_W-1:0]  thr_down;
  logic [PROB_W-1:0]  thr_up;
  logic [LEVEL_W-1:0] dec_level;
  logic               dec_fault;
  logic               dec_up;

  mlc_fi_lfsr #(
    .LFSR_W(LFSR_W), .DRAW_W(PROB_W),
    .MASK(mlc_fi_pkg::LFSR_MASK), .RESET_SEED(RESET_SEED)
  ) u_rng (
    .clk(clk), .rst(rst), .load(seed_load), .seed(seed_value),
    .advance(in_valid), .state(rng_state), .draw(rng_draw)
  );

  mlc_fi_thresh_bank #(.LEVEL_W(LEVEL_W), .PROB_W(PROB_W)) u_bank (
    .clk(clk), .rst(rst), .we(thr_we), .wr_level(thr_level),
    .wr_dir(thr_dir), .wr_data(thr_data), .rd_level(in_level),
    .rd_down(thr_down), .rd_up(thr_up)
  );

  mlc_fi_decide #(.LEVEL_W(LEVEL_W), .PROB_W(PROB_W)) u_dec (
    .level(in_level), .levels_cfg(levels_cfg), .draw(rng_draw),
    .p_down(thr_down), .p_up(thr_up), .level_out(dec_level),
    .fault(dec_fault), .dir_up(dec_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_level  <= '0;
      out_fault  <= 1'b0;
      out_dir_up <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_level  <= in_valid ? dec_level : '0;
      out_fault  <= in_valid & dec_fault;
      out_dir_up <= in_valid & dec_up;
    end
  end
endmodule

// File: rtl/mlc_fi_checker.sv
module mlc_fi_checker #(
  parameter int LEVEL_W = 4,
  parameter int LFSR_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               seed_load,
  input logic               in_valid,
  input logic [LEVEL_W-1:0] in_level,
  input logic [LEVEL_W:0]   levels_cfg,
  input logic               out_valid,
  input logic [LEVEL_W-1:0] out_level,
  input logic               out_fault,
  input logic               out_dir_up,
  input logic [LFSR_W-1:0]  rng_state
);
  localparam int CFG_W = LEVEL_W + 1;
  localparam logic [CFG_W-1:0] MAX_LEV = CFG_W'(1 << LEVEL_W);

  logic cfg_plain;
  assign cfg_plain = (levels_cfg >= CFG_W'(2)) && (levels_cfg <= MAX_LEV);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_step_one_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_fault ?
      (out_dir_up ? (out_level == $past(in_level) + LEVEL_W'(1))
                  : (out_level == $past(in_level) - LEVEL_W'(1)))
      : (out_level == $past(in_level) && !out_dir_up)));
  assert_quiet_flags_R12: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_fault && !out_dir_up));
  assert_l0_no_down_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_level == '0) |=> !(out_fault && !out_dir_up));
  assert_top_no_up_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_plain && {1'b0, in_level} == levels_cfg - CFG_W'(1))
      |=> !(out_fault && out_dir_up));
  assert_range_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_plain && {1'b0, in_level} >= levels_cfg) |=> !out_fault);
  assert_rng_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    rng_state != '0);
  assert_rng_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !seed_load) |=> $stable(rng_state));
endmodule

bind mlc_fault_inject mlc_fi_checker #(.LEVEL_W(LEVEL_W), .LFSR_W(mlc_fi_pkg::LFSR_W)) u_chk (
  .clk(clk), .rst(rst), .seed_load(seed_load), .in_valid(in_valid),
  .in_level(in_level), .levels_cfg(levels_cfg), .out_valid(out_valid),
  .out_level(out_level), .out_fault(out_fault), .out_dir_up(out_dir_up),
  .rng_state(rng_state)
);

// File: tb/test_mlc_fault_inject.sv
module test_mlc_fault_inject;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seed_load = 1'b0;
  logic [31:0] seed_value = '0;
  logic        thr_we = 1'b0;
  logic [3:0]  thr_level = '0;
  logic        thr_dir = 1'b0;
  logic [15:0] thr_data = '0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_level = '0;
  logic [4:0]  levels_cfg = 5'd16;
  logic        out_valid;
  logic [3:0]  out_level;
  logic        out_fault;
  logic        out_dir_up;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_state;
  logic [15:0] m_dn [16];
  logic [15:0] m_up [16];

  always #10 clk = ~clk;

  mlc_fault_inject i_mlc_fault_inject (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .thr_we(thr_we), .thr_level(thr_level), .thr_dir(thr_dir),
    .thr_data(thr_data), .in_valid(in_valid), .in_level(in_level),
    .levels_cfg(levels_cfg), .out_valid(out_valid), .out_level(out_level),
    .out_fault(out_fault), .out_dir_up(out_dir_up)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  // expected {valid, fault, up, level}
  function automatic logic [6:0] expect_cell(input logic [3:0] lvl, input logic [4:0] cfg,
                                             input logic [31:0] s);
    int n, top, dn, up, r;
    n = (cfg < 2) ? 2 : (cfg > 16) ? 16 : int'(cfg);
    top = n - 1;
    r = int'(s[31:16] ^ s[15:0]);
    if (int'(lvl) > top) return {3'b100, lvl};
    dn = (lvl == 0) ? 0 : int'(m_dn[lvl]);
    up = (int'(lvl) == top) ? 0 : int'(m_up[lvl]);
    if (r < dn) return {3'b110, lvl - 4'd1};
    if (r < dn + up) return {3'b111, lvl + 4'd1};
    return {3'b100, lvl};
  endfunction

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got v/f/u/lvl=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {out_valid, out_fault, out_dir_up, out_level};
  endfunction

  task automatic send(input string req, input logic [3:0] lvl);
    logic [6:0] e;
    in_valid = 1'b1;
    in_level = lvl;
    e = expect_cell(lvl, levels_cfg, m_state);
    m_state = step(m_state);
    @(negedge clk);
    check(req, outs(), e);
  endtask

  task automatic idle(input string req);
    in_valid = 1'b0;
    @(negedge clk);
    check(req, outs(), 7'b0);
  endtask

  task automatic wthr(input logic [3:0] lvl, input logic dir, input logic [15:0] v);
    in_valid = 1'b0;
    thr_we = 1'b1; thr_level = lvl; thr_dir = dir; thr_data = v;
    @(negedge clk);
    thr_we = 1'b0;
    if (dir) m_up[lvl] = v; else m_dn[lvl] = v;
  endtask

  task automatic load_seed(input logic [31:0] v);
    in_valid = 1'b0;
    seed_load = 1'b1; seed_value = v;
    @(negedge clk);
    seed_load = 1'b0;
    m_state = (v == 0) ? 32'h1 : v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [4:0] cfgs [7];
    logic [6:0] e;
    cfgs[0] = 5'd2; cfgs[1] = 5'd3; cfgs[2] = 5'd5; cfgs[3] = 5'd9;
    cfgs[4] = 5'd16; cfgs[5] = 5'd0; cfgs[6] = 5'd20;
    m_state = 32'h1;
    for (int i = 0; i < 16; i++) begin m_dn[i] = '0; m_up[i] = '0; end

    repeat (3) @(negedge clk);
    check("R1 during reset", outs(), 7'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", outs(), 7'b0);

    // R11 R2: cleared thresholds give transparent pipeline
    levels_cfg = 5'd16;
    for (int rep = 0; rep < 4; rep++)
      for (int l = 0; l < 16; l++) send("R11 transparent", 4'(l));
    idle("R2 idle after burst");

    // R10: program distinct thresholds
    for (int l = 0; l < 16; l++) begin
      wthr(4'(l), 1'b0, 16'h1800 + 16'(l) * 16'h0700);
      wthr(4'(l), 1'b1, 16'h2400 + 16'(l) * 16'h0500);
    end

    // R5 R6 R7 R8 R9 sweep over level counts incl. clamped ones
    for (int c = 0; c < 7; c++) begin
      levels_cfg = cfgs[c];
      for (int rep = 0; rep < 8; rep++)
        for (int l = 0; l < 16; l++) send("R5/R6 sweep (R8 R9)", 4'(l));
      idle("R12 flags idle");
    end

    // R7: level 0 down threshold saturated, must never read low
    levels_cfg = 5'd16;
    wthr(4'd0, 1'b0, 16'hFFFF);
    wthr(4'd0, 1'b1, 16'h0000);
    for (int k = 0; k < 32; k++) send("R7 level zero", 4'd0);

    // R8: top level up threshold saturated, never reads high
    wthr(4'd15, 1'b1, 16'hFFFF);
    wthr(4'd15, 1'b0, 16'h0000);
    for (int k = 0; k < 32; k++) send("R8 top level", 4'd15);
    levels_cfg = 5'd4;
    wthr(4'd3, 1'b1, 16'hFFFF);
    wthr(4'd3, 1'b0, 16'h0000);
    for (int k = 0; k < 16; k++) send("R8 top of four", 4'd3);
    for (int k = 0; k < 16; k++) send("R9 above four", 4'(4 + k % 12));

    // R6: 17-bit band, saturated both ways
    levels_cfg = 5'd16;
    wthr(4'd7, 1'b0, 16'hFFFF);
    wthr(4'd7, 1'b1, 16'hFFFF);
    for (int k = 0; k < 32; k++) send("R6 wide band", 4'd7);

    // R3: idle cycles do not advance the generator
    repeat (5) idle("R3 hold");
    for (int k = 0; k < 16; k++) send("R3 after hold", 4'(k));

    // R4: seed loads, zero seed replaced
    load_seed(32'h1234_5678);
    for (int k = 0; k < 32; k++) send("R4 seed", 4'(k % 16));
    load_seed(32'h0);
    for (int k = 0; k < 16; k++) send("R4 zero seed", 4'(k));
    // R4: load in same cycle as a cell
    in_valid = 1'b1; in_level = 4'd5;
    seed_load = 1'b1; seed_value = 32'hCAFE_F00D;
    e = expect_cell(4'd5, levels_cfg, m_state);
    m_state = 32'hCAFE_F00D;
    @(negedge clk);
    seed_load = 1'b0;
    check("R4 same-cycle load", outs(), e);
    for (int k = 0; k < 16; k++) send("R4 after same-cycle load", 4'(k));

    // R10: write and read of the same level in one cycle
    wthr(4'd5, 1'b0, 16'h0000);
    wthr(4'd5, 1'b1, 16'h0000);
    in_valid = 1'b1; in_level = 4'd5;
    thr_we = 1'b1; thr_level = 4'd5; thr_dir = 1'b0; thr_data = 16'hFFFF;
    e = expect_cell(4'd5, levels_cfg, m_state);
    m_state = step(m_state);
    @(negedge clk);
    thr_we = 1'b0;
    m_dn[5] = 16'hFFFF;
    check("R10 old value same cycle", outs(), e);
    for (int k = 0; k < 8; k++) send("R10 new value", 4'd5);
    idle("R12 final idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule